// File: doc/BRIEF.md
# Dual Reloadable Down-Counter Timer

This peripheral holds two independent down-counters behind one word-addressed register port. Each counter has a current-count register and a reload register. A shared control word gives each counter a run bit and an auto-reload bit. A running counter steps down by one on every clock. When it expires it either restarts from its reload register (periodic mode) or stops at zero and drops its own run bit (one-shot mode).

Every expiry sets a sticky status bit in a shared cause register. Software clears a status bit by writing a word in which that bit is zero. A mask register selects which status bits drive the single interrupt output. Control and status positions that a watchdog would use are reserved: they read as zero and ignore writes.

For a free-running time base, load 0xFFFFFFFF into both the count and reload registers, set run and auto-reload, and leave the mask bit clear. Elapsed clocks are then 0xFFFFFFFF minus the count.

Top module: `dual_downcount_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: While its run bit is set, a counter whose value is above 1 decreases by exactly one per clock. While the run bit is clear, the value holds.
- R3: In periodic mode, a running counter at value 1 or 0 loads its reload value on the next clock. A reload value R therefore gives an expiry every R clocks.
- R4: In one-shot mode, a running counter at value 1 or 0 goes to zero on the next clock and stays there. Hardware clears its run bit on that same clock.
- R5: Every expiry of timer x sets cause bit x+1. The bit stays set until software clears it.
- R6: A write to the cause register clears each bit written as 0 and leaves each bit written as 1 unchanged. An expiry in the same cycle as a clearing write leaves the bit set.
- R7: `irq_o` is high exactly when some cause bit is set and its mask bit is also set.
- R8: A write to a count register takes effect on the next clock, even while the counter runs. Counting then continues from the written value.
- R9: The register map (word addresses) is: 0 control, 1 cause, 2 mask, 4+2x count of timer x, 5+2x reload of timer x. Control bit 2x is the run bit of timer x and bit 2x+1 is its auto-reload bit. Control bits 4 and above, cause/mask bits 0, 3 and above, and address 3 read zero and ignore writes.
- R10: With 0xFFFFFFFF in both the count and reload registers, in periodic mode, 0xFFFFFFFF minus the count equals the number of clocks since the counter was started. The interrupt stays low while that timer's mask bit is clear.
- R11: Starting a counter whose value is zero counts as an expiry on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count step per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
A register write lands on the rising edge where `bus_we` is sampled. A counter started by that edge first steps on the following edge, so k clocks after the starting write the count reads V-k.

An expiry is taken while the count is 1 (or 0). On the next edge the new count, the cause bit and any run-bit clear all appear together. The combinational read and the interrupt follow in the same cycle.

The bench drives and samples at falling edges and reads back through the combinational port without spending clocks. Each expected value is computed from the number of rising edges since the starting write. The same-cycle clear-versus-expiry case is placed by counting edges to the second expiry of a periodic counter.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_CAUSE = 3'd1;
   localparam logic [ADDR_W-1:0] A_MASK  = 3'd2;

   // control word: run bit, then auto-reload bit, per timer
   function automatic int run_pos(input int x);
      return 2 * x;
   endfunction
   function automatic int rel_pos(input int x);
      return 2 * x + 1;
   endfunction
   // status bit per timer (bit 0 and bit 3 reserved)
   function automatic int cause_pos(input int x);
      return x + 1;
   endfunction
   function automatic logic [ADDR_W-1:0] cnt_addr(input int x);
      return ADDR_W'(4 + 2 * x);
   endfunction
   function automatic logic [ADDR_W-1:0] rld_addr(input int x);
      return ADDR_W'(5 + 2 * x);
   endfunction
endpackage

// File: rtl/dtmr_channel.sv
module dtmr_channel #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             reload_en_i,
   input  logic             cnt_we_i,
   input  logic             rld_we_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] rld_o,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] rld_q;

   assign expire_o = run_i && (cnt_q <= ONE);
   assign cnt_o    = cnt_q;
   assign rld_o    = rld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rld_q <= '0;
      end else begin
         if (rld_we_i) rld_q <= wdata_i;
         if (cnt_we_i) begin
            cnt_q <= wdata_i;
         end else if (run_i) begin
            if (cnt_q <= ONE) cnt_q <= reload_en_i ? rld_q : '0;
            else              cnt_q <= cnt_q - ONE;
         end
      end
   end

   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !cnt_we_i && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE)); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !cnt_we_i) |=> $stable(cnt_q)); // R2
   AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && reload_en_i && !cnt_we_i) |=> (cnt_q == $past(rld_q))); // R3
   AST_ONESHOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && !reload_en_i && !cnt_we_i) |=> (cnt_q == '0)); // R4
   AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we_i |=> (cnt_q == $past(wdata_i))); // R8
endmodule

// File: rtl/dtmr_cause.sv
module dtmr_cause #(
   parameter int                 DATA_W = 32,
   parameter logic [DATA_W-1:0]  IMPL   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cause_we_i,
   input  logic              mask_we_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] set_i,
   output logic [DATA_W-1:0] cause_o,
   output logic [DATA_W-1:0] mask_o,
   output logic              irq_o
);
   logic [DATA_W-1:0] cause_q;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] kept;

   always_comb begin
      kept = cause_we_i ? (cause_q & wdata_i) : cause_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= '0;
         mask_q  <= '0;
      end else begin
         cause_q <= (kept | set_i) & IMPL;
         if (mask_we_i) mask_q <= wdata_i & IMPL;
      end
   end

   assign cause_o = cause_q;
   assign mask_o  = mask_q;
   assign irq_o   = |(cause_q & mask_q);

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_i & IMPL)) |=> ((cause_q & $past(set_i & IMPL)) == $past(set_i & IMPL))); // R6
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !cause_we_i |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R5
   AST_NO_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq_o); // R7
endmodule

// File: rtl/dual_downcount_timer.sv
module dual_downcount_timer
   import dtmr_pkg::*;
#(
   parameter int NUM_TMR = 2,
   parameter int CNT_W   = 32,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   localparam int CTRL_W = 2 * NUM_TMR;

   function automatic logic [DATA_W-1:0] impl_bits();
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < NUM_TMR; i++) m[cause_pos(i)] = 1'b1;
      return m;
   endfunction
   localparam logic [DATA_W-1:0] IMPL = impl_bits();

   if (NUM_TMR < 1 || NUM_TMR > 2) begin : g_bad_num
      $error("NUM_TMR must be 1 or 2: higher positions are reserved");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must lie in 2..DATA_W");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be at least 8");
   end

   logic [CTRL_W-1:0]  ctrl_q;
   logic [CTRL_W-1:0]  hw_clr;
   logic [NUM_TMR-1:0] expire;
   logic [DATA_W-1:0]  set_vec;
   logic [DATA_W-1:0]  cause_w;
   logic [DATA_W-1:0]  mask_w;
   logic [CNT_W-1:0]   cnt_w [NUM_TMR];
   logic [CNT_W-1:0]   rld_w [NUM_TMR];
   logic               ctrl_we;

   assign ctrl_we = bus_we && (bus_addr == A_CTRL);

   for (genvar x = 0; x < NUM_TMR; x++) begin : g_tmr
      dtmr_channel #(.CNT_W(CNT_W)) i_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .run_i       (ctrl_q[run_pos(x)]),
         .reload_en_i (ctrl_q[rel_pos(x)]),
         .cnt_we_i    (bus_we && (bus_addr == cnt_addr(x))),
         .rld_we_i    (bus_we && (bus_addr == rld_addr(x))),
         .wdata_i     (bus_wdata[CNT_W-1:0]),
         .cnt_o       (cnt_w[x]),
         .rld_o       (rld_w[x]),
         .expire_o    (expire[x])
      );

      AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
         (expire[x] && !ctrl_q[rel_pos(x)] && !ctrl_we) |=> !ctrl_q[run_pos(x)]); // R4
   end

   always_comb begin
      hw_clr  = '0;
      set_vec = '0;
      for (int x = 0; x < NUM_TMR; x++) begin
         hw_clr[run_pos(x)]    = expire[x] && !ctrl_q[rel_pos(x)];
         set_vec[cause_pos(x)] = expire[x];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_we) ctrl_q <= bus_wdata[CTRL_W-1:0];
      else              ctrl_q <= ctrl_q & ~hw_clr;
   end

   dtmr_cause #(.DATA_W(DATA_W), .IMPL(IMPL)) i_cause (
      .clk        (clk),
      .rst_n      (rst_n),
      .cause_we_i (bus_we && (bus_addr == A_CAUSE)),
      .mask_we_i  (bus_we && (bus_addr == A_MASK)),
      .wdata_i    (bus_wdata),
      .set_i      (set_vec),
      .cause_o    (cause_w),
      .mask_o     (mask_w),
      .irq_o      (irq_o)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
         A_CAUSE: bus_rdata = cause_w;
         A_MASK:  bus_rdata = mask_w;
         default: begin
            for (int x = 0; x < NUM_TMR; x++) begin
               if (bus_addr == cnt_addr(x)) bus_rdata[CNT_W-1:0] = cnt_w[x];
               if (bus_addr == rld_addr(x)) bus_rdata[CNT_W-1:0] = rld_w[x];
            end
         end
      endcase
   end

   AST_RSVD_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_CTRL) |-> (bus_rdata[DATA_W-1:CTRL_W] == '0)); // R9
endmodule

// File: tb/test_dual_downcount_timer.sv
module test_dual_downcount_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   dual_downcount_timer i_dual_downcount_timer (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] e;
      wait_clk(2);
      rst_n = 1'b1;
      wait_clk(1);
      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         chk("R1", v, 32'h0);
      end
      chk("R1 irq", {31'h0, irq_o}, 32'h0);

      // R2 hold while stopped
      wr(3'd4, 32'd20);
      wait_clk(3);
      rd(3'd4, v); chk("R2 hold", v, 32'd20);

      // R2/R3 periodic sweep over reload values
      for (int r = 1; r <= 4; r++) begin
         int vs;
         vs = r + 2;
         wr(3'd5, 32'(r));
         wr(3'd4, 32'(vs));
         wr(3'd0, 32'h3);
         for (int k = 1; k <= 2 * r + 3; k++) begin
            wait_clk(1);
            if (k < vs) e = 32'(vs - k);
            else        e = 32'(r - ((k - vs) % r));
            rd(3'd4, v);
            chk(k < vs ? "R2 step" : "R3 reload", v, e);
         end
         wr(3'd0, 32'h0);
         rd(3'd1, v); chk("R5 periodic cause", v, 32'h2);
         wr(3'd1, 32'h0);
      end

      // R4/R5 one-shot sweep
      for (int s = 1; s <= 4; s++) begin
         wr(3'd4, 32'(s));
         wr(3'd0, 32'h1);
         wait_clk(s - 1);
         rd(3'd4, v); chk("R4 before", v, 32'h1);
         rd(3'd1, v); chk("R5 before", v, 32'h0);
         wait_clk(1);
         rd(3'd4, v); chk("R4 zero", v, 32'h0);
         rd(3'd0, v); chk("R4 run clr", v, 32'h0);
         rd(3'd1, v); chk("R5 set", v, 32'h2);
         wait_clk(3);
         rd(3'd4, v); chk("R4 stays", v, 32'h0);
         rd(3'd1, v); chk("R5 sticky", v, 32'h2);
         if (s < 4) wr(3'd1, 32'hFFFF_FFFD);
      end

      // R7 masking, R6 clear by zero
      rd(3'd1, v); chk("R7 pre", v, 32'h2);
      chk("R7 mask off", {31'h0, irq_o}, 32'h0);
      wr(3'd2, 32'h2); #1 chk("R7 mask on", {31'h0, irq_o}, 32'h1);
      wr(3'd2, 32'h4); #1 chk("R7 other mask", {31'h0, irq_o}, 32'h0);
      wr(3'd1, 32'hFFFF_FFFF);
      rd(3'd1, v); chk("R6 ones keep", v, 32'h2);
      wr(3'd1, 32'hFFFF_FFFD);
      rd(3'd1, v); chk("R6 zero clears", v, 32'h0);
      wr(3'd2, 32'h0);

      // R5 timer 1 one-shot uses cause bit 2 and run bit 2
      wr(3'd6, 32'd2);
      wr(3'd0, 32'h4);
      wait_clk(2);
      rd(3'd1, v); chk("R5 timer1 bit", v, 32'h4);
      rd(3'd0, v); chk("R4 timer1 run clr", v, 32'h0);
      wr(3'd1, 32'h0);

      // R6 set wins over clear in same cycle
      wr(3'd5, 32'd4);
      wr(3'd4, 32'd4);
      wr(3'd0, 32'h3);
      wait_clk(4);
      rd(3'd1, v); chk("R6 first expiry", v, 32'h2);
      wait_clk(3);
      wr(3'd1, 32'h0);
      rd(3'd1, v); chk("R6 set wins", v, 32'h2);
      wr(3'd1, 32'h0);
      rd(3'd1, v); chk("R6 later clear", v, 32'h0);
      wr(3'd0, 32'h0);
      wr(3'd1, 32'h0);

      // R8 write while running
      wr(3'd4, 32'd10);
      wr(3'd0, 32'h1);
      wait_clk(3);
      rd(3'd4, v); chk("R8 before", v, 32'd7);
      wr(3'd4, 32'd20);
      rd(3'd4, v); chk("R8 loaded", v, 32'd20);
      wait_clk(2);
      rd(3'd4, v); chk("R8 continue", v, 32'd18);
      wr(3'd0, 32'h0);

      // R11 start from zero
      wr(3'd4, 32'h0);
      wr(3'd1, 32'h0);
      wr(3'd0, 32'h1);
      wait_clk(1);
      rd(3'd1, v); chk("R11 cause", v, 32'h2);
      rd(3'd0, v); chk("R11 run clr", v, 32'h0);
      wr(3'd1, 32'h0);

      // R9 reserved positions
      wr(3'd0, 32'hFFFF_FFF0);
      rd(3'd0, v); chk("R9 ctrl rsvd", v, 32'h0);
      wr(3'd2, 32'hFFFF_FFFF);
      rd(3'd2, v); chk("R9 mask rsvd", v, 32'h6);
      wr(3'd3, 32'hFFFF_FFFF);
      rd(3'd3, v); chk("R9 hole", v, 32'h0);
      wr(3'd2, 32'h0);

      // R10 free running timer 1
      wr(3'd6, 32'hFFFF_FFFF);
      wr(3'd7, 32'hFFFF_FFFF);
      wr(3'd0, 32'hC);
      wait_clk(37);
      rd(3'd6, v); chk("R10 elapsed", 32'hFFFF_FFFF - v, 32'd37);
      chk("R10 irq", {31'h0, irq_o}, 32'h0);
      rd(3'd0, v); chk("R10 ctrl", v, 32'hC);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule